// File: doc/BRIEF.md
# Programmer-Visible Register Set with Packed Status Word

This block holds the architectural state of a small 16-bit processor: eight general registers, a program counter, a stack pointer and a processor status word. It only stores, updates and returns values. The arithmetic unit, the memory interface and the instruction sequencer sit outside the block and drive its control inputs.

The general file has two combinational read ports and one clocked write port. Index 0 is a constant-zero slot. The program counter can be loaded or stepped forward. The stack pointer can be loaded, stepped up for a pop or stepped down for a push. The status word keeps four condition flags and an interrupt-enable bit in its low five bits. It can be overwritten as a whole, or each flag can be refreshed on its own enable. Every update is synchronous, and a synchronous reset returns all state to zero.

Top module: `regset_top`

## Requirements
- R1: While `rst` is high at a rising edge, every general register, `pcOut`, `spOut` and `statusOut` becomes 0x0000 after that edge.
- R2: A write with `wrEn`=1 to index 1..7 is visible on both read ports after the rising edge. During the cycle of the write, a read of that index still returns the old value.
- R3: A read of index 0 on either port returns 0x0000. A write to index 0 changes no register.
- R4: `pcLoad`=1 makes `pcOut` equal `pcLoadVal` after the edge, even when `pcInc` is also 1. `pcInc` alone adds 1 modulo 2^16.
- R5: `spLoad`=1 loads `spLoadVal` and takes priority over the step inputs. With no load, `spInc` alone adds 1 and `spDec` alone subtracts 1, both modulo 2^16. `spInc` and `spDec` together leave SP unchanged.
- R6: The flags Z, N, C and V sit at `statusOut` bits 3, 2, 1 and 0. Bit i of `flagEn` loads bit i of `flagIn` into status bit i. A flag whose enable is 0 keeps its value.
- R7: The interrupt-enable bit sits at `statusOut` bit 4. It takes `eiIn` when `eiWrEn`=1 and otherwise holds.
- R8: `psrWrEn`=1 copies `psrWrData[4:0]` into status bits 4..0 and overrides `flagEn` and `eiWrEn` in that cycle. `statusOut[15:5]` always reads 0.
- R9: With none of its update controls active, PC, SP and the status word each keep their value across an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 3 | Read port A index |
| rdAddrB | input | 3 | Read port B index |
| rdDataA | output | 16 | Read port A data (combinational) |
| rdDataB | output | 16 | Read port B data (combinational) |
| wrEn | input | 1 | General register write enable |
| wrAddr | input | 3 | Write index |
| wrData | input | 16 | Write data |
| pcLoad | input | 1 | Load program counter |
| pcInc | input | 1 | Increment program counter |
| pcLoadVal | input | 16 | Program counter load value |
| pcOut | output | 16 | Program counter |
| spLoad | input | 1 | Load stack pointer |
| spInc | input | 1 | Increment stack pointer (pop) |
| spDec | input | 1 | Decrement stack pointer (push) |
| spLoadVal | input | 16 | Stack pointer load value |
| spOut | output | 16 | Stack pointer |
| flagEn | input | 4 | Per-flag update enables, bit 3 Z down to bit 0 V |
| flagIn | input | 4 | New flag values, same bit order |
| eiWrEn | input | 1 | Interrupt-enable bit update |
| eiIn | input | 1 | New interrupt-enable value |
| psrWrEn | input | 1 | Whole status word write |
| psrWrData | input | 16 | Status word write data |
| statusOut | output | 16 | Status word, bits 15..5 zero |

## Verification
Read data is due in the same cycle as the address, so the bench checks both ports one time step after driving the inputs, before the clock edge. A write from that cycle must not yet appear there. PC, SP, the status word and the register contents are each due exactly one rising edge after the control that changes them. The bench updates its model at that edge and compares at the following falling edge, before it drives the next stimulus. The random mix of loads, steps, flag masks and R0 writes is followed by directed cases for wraparound, conflicting step inputs and status writes that set the high bits.

// File: rtl/regset_pkg.sv
package regset_pkg;
  parameter int unsigned REG_CNT  = 8;
  parameter int unsigned FLAG_CNT = 4;
  localparam int unsigned IDX_W   = $clog2(REG_CNT);
  localparam int unsigned PSR_W   = FLAG_CNT + 1;
  localparam int unsigned EI_POS  = FLAG_CNT;

  typedef enum logic [1:0] {PC_HOLD, PC_LOAD, PC_INC} pcOp_e;
  typedef enum logic [1:0] {SP_HOLD, SP_LOAD, SP_INC, SP_DEC} spOp_e;

  typedef struct packed {
    logic [REG_CNT-1:0]  regWe;
    pcOp_e               pcOp;
    spOp_e               spOp;
    logic                psrLoad;
    logic [FLAG_CNT-1:0] flagWe;
    logic                eiWe;
  } ctl_t;
endpackage

// File: rtl/regset_ctrl.sv
module regset_ctrl
  import regset_pkg::*;
(
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic             pcLoad,
  input  logic             pcInc,
  input  logic             spLoad,
  input  logic             spInc,
  input  logic             spDec,
  input  logic [FLAG_CNT-1:0] flagEn,
  input  logic             eiWrEn,
  input  logic             psrWrEn,
  output ctl_t             ctl
);
  logic [REG_CNT-1:0] weVec;

  genvar g;
  generate
    for (g = 0; g < REG_CNT; g++) begin : gWe
      if (g == 0) begin : gZero
        assign weVec[g] = 1'b0;
      end else begin : gReal
        assign weVec[g] = wrEn && (wrAddr == IDX_W'(g));
      end
    end
  endgenerate

  always_comb begin
    ctl.regWe   = weVec;
    ctl.pcOp    = pcLoad ? PC_LOAD : (pcInc ? PC_INC : PC_HOLD);
    if (spLoad)              ctl.spOp = SP_LOAD;
    else if (spInc && !spDec) ctl.spOp = SP_INC;
    else if (spDec && !spInc) ctl.spOp = SP_DEC;
    else                      ctl.spOp = SP_HOLD;
    ctl.psrLoad = psrWrEn;
    ctl.flagWe  = psrWrEn ? '0 : flagEn;
    ctl.eiWe    = eiWrEn && !psrWrEn;
  end
endmodule

// File: rtl/regset_dp.sv
module regset_dp
  import regset_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [IDX_W-1:0]  rdAddrA,
  input  logic [IDX_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcLoadVal,
  input  logic [DATA_W-1:0] spLoadVal,
  input  logic [FLAG_CNT-1:0] flagIn,
  input  logic              eiIn,
  input  logic [PSR_W-1:0]  psrWrBits,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] spOut,
  output logic [PSR_W-1:0]  psrOut
);
  logic [DATA_W-1:0] regRd [REG_CNT];
  logic [DATA_W-1:0] pcQ, spQ;
  logic [PSR_W-1:0]  psrQ;

  genvar g;
  generate
    for (g = 0; g < REG_CNT; g++) begin : gReg
      if (g == 0) begin : gZero
        assign regRd[g] = '0;
      end else begin : gStore
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
          if (rst)               q <= '0;
          else if (ctl.regWe[g]) q <= wrData;
        end
        assign regRd[g] = q;
      end
    end
  endgenerate

  assign rdDataA = regRd[rdAddrA];
  assign rdDataB = regRd[rdAddrB];

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else begin
      unique case (ctl.pcOp)
        PC_LOAD: pcQ <= pcLoadVal;
        PC_INC:  pcQ <= pcQ + DATA_W'(1);
        default: pcQ <= pcQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) spQ <= '0;
    else begin
      unique case (ctl.spOp)
        SP_LOAD: spQ <= spLoadVal;
        SP_INC:  spQ <= spQ + DATA_W'(1);
        SP_DEC:  spQ <= spQ - DATA_W'(1);
        default: spQ <= spQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) psrQ <= '0;
    else if (ctl.psrLoad) psrQ <= psrWrBits;
    else begin
      for (int i = 0; i < int'(FLAG_CNT); i++)
        if (ctl.flagWe[i]) psrQ[i] <= flagIn[i];
      if (ctl.eiWe) psrQ[EI_POS] <= eiIn;
    end
  end

  assign pcOut  = pcQ;
  assign spOut  = spQ;
  assign psrOut = psrQ;
endmodule

// File: rtl/regset_top.sv
module regset_top
  import regset_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rdAddrA,
  input  logic [IDX_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcLoad,
  input  logic              pcInc,
  input  logic [DATA_W-1:0] pcLoadVal,
  output logic [DATA_W-1:0] pcOut,
  input  logic              spLoad,
  input  logic              spInc,
  input  logic              spDec,
  input  logic [DATA_W-1:0] spLoadVal,
  output logic [DATA_W-1:0] spOut,
  input  logic [FLAG_CNT-1:0] flagEn,
  input  logic [FLAG_CNT-1:0] flagIn,
  input  logic              eiWrEn,
  input  logic              eiIn,
  input  logic              psrWrEn,
  input  logic [DATA_W-1:0] psrWrData,
  output logic [DATA_W-1:0] statusOut
);
  ctl_t             ctl;
  logic [PSR_W-1:0] psrBits;

  regset_ctrl uCtrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .pcLoad(pcLoad), .pcInc(pcInc),
    .spLoad(spLoad), .spInc(spInc), .spDec(spDec), .flagEn(flagEn),
    .eiWrEn(eiWrEn), .psrWrEn(psrWrEn), .ctl(ctl)
  );

  regset_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .wrData(wrData), .pcLoadVal(pcLoadVal), .spLoadVal(spLoadVal),
    .flagIn(flagIn), .eiIn(eiIn), .psrWrBits(psrWrData[PSR_W-1:0]),
    .pcOut(pcOut), .spOut(spOut), .psrOut(psrBits)
  );

  assign statusOut = {{(DATA_W-PSR_W){1'b0}}, psrBits};
endmodule

// File: rtl/regset_chk.sv
module regset_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        rdAddrA,
  input logic [2:0]        rdAddrB,
  input logic [DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0] rdDataB,
  input logic              pcLoad,
  input logic              pcInc,
  input logic [DATA_W-1:0] pcLoadVal,
  input logic [DATA_W-1:0] pcOut,
  input logic              spLoad,
  input logic              spInc,
  input logic              spDec,
  input logic [DATA_W-1:0] spOut,
  input logic [3:0]        flagEn,
  input logic              eiWrEn,
  input logic              psrWrEn,
  input logic [DATA_W-1:0] statusOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pcOut == '0 && spOut == '0 && statusOut == '0));

  // R3
  r0_port_a_chk: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == 3'd0) |-> (rdDataA == '0));

  // R3
  r0_port_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rdAddrB == 3'd0) |-> (rdDataB == '0));

  // R4
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    pcLoad |=> (pcOut == $past(pcLoadVal)));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!pcLoad && pcInc) |=> (pcOut == $past(pcOut) + DATA_W'(1)));

  // R5
  sp_push_chk: assert property (@(posedge clk) disable iff (rst)
    (!spLoad && spDec && !spInc) |=> (spOut == $past(spOut) - DATA_W'(1)));

  // R5
  sp_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    (!spLoad && spDec && spInc) |=> $stable(spOut));

  // R8
  psr_upper_chk: assert property (@(posedge clk) disable iff (rst)
    statusOut[DATA_W-1:5] == '0);

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!psrWrEn && !eiWrEn && flagEn == 4'b0) |=> $stable(statusOut));

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pcLoad && !pcInc) |=> $stable(pcOut));
endmodule

bind regset_top regset_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
  .rdDataA(rdDataA), .rdDataB(rdDataB), .pcLoad(pcLoad), .pcInc(pcInc),
  .pcLoadVal(pcLoadVal), .pcOut(pcOut), .spLoad(spLoad), .spInc(spInc),
  .spDec(spDec), .spOut(spOut), .flagEn(flagEn), .eiWrEn(eiWrEn),
  .psrWrEn(psrWrEn), .statusOut(statusOut)
);

// File: tb/regset_top_test.sv
`timescale 1ns/1ps
module regset_top_test;
  logic clk = 1'b0;
  logic rst;
  logic [2:0]  rdAddrA, rdAddrB, wrAddr;
  logic [15:0] rdDataA, rdDataB, wrData, pcLoadVal, pcOut, spLoadVal, spOut;
  logic [15:0] psrWrData, statusOut;
  logic wrEn, pcLoad, pcInc, spLoad, spInc, spDec, eiWrEn, eiIn, psrWrEn;
  logic [3:0] flagEn, flagIn;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  logic [15:0] mReg [8];
  logic [15:0] mPc, mSp;
  logic [4:0]  mPsr;

  always #10 clk = ~clk;

  regset_top uut (
    .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pcLoad(pcLoad), .pcInc(pcInc), .pcLoadVal(pcLoadVal),
    .pcOut(pcOut), .spLoad(spLoad), .spInc(spInc), .spDec(spDec),
    .spLoadVal(spLoadVal), .spOut(spOut), .flagEn(flagEn), .flagIn(flagIn),
    .eiWrEn(eiWrEn), .eiIn(eiIn), .psrWrEn(psrWrEn), .psrWrData(psrWrData),
    .statusOut(statusOut)
  );

  function automatic logic [15:0] expPc(logic [15:0] cur);
    if (pcLoad) return pcLoadVal;
    if (pcInc)  return cur + 16'd1;
    return cur;
  endfunction

  function automatic logic [15:0] expSp(logic [15:0] cur);
    if (spLoad) return spLoadVal;
    if (spInc && !spDec) return cur + 16'd1;
    if (spDec && !spInc) return cur - 16'd1;
    return cur;
  endfunction

  function automatic logic [4:0] expPsr(logic [4:0] cur);
    logic [4:0] n = cur;
    if (psrWrEn) return psrWrData[4:0];
    for (int i = 0; i < 4; i++) if (flagEn[i]) n[i] = flagIn[i];
    if (eiWrEn) n[4] = eiIn;
    return n;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; wrAddr = 0; wrData = 0; pcLoad = 0; pcInc = 0; pcLoadVal = 0;
    spLoad = 0; spInc = 0; spDec = 0; spLoadVal = 0; flagEn = 0; flagIn = 0;
    eiWrEn = 0; eiIn = 0; psrWrEn = 0; psrWrData = 0;
  endtask

  // Called just after a falling edge with inputs already driven.
  task automatic step();
    #1;
    // R2 R3: combinational reads show pre-edge contents
    check("R2/R3 readA", rdDataA, (rdAddrA == 0) ? 16'h0 : mReg[rdAddrA]);
    check("R2/R3 readB", rdDataB, (rdAddrB == 0) ? 16'h0 : mReg[rdAddrB]);
    @(posedge clk);
    if (wrEn && wrAddr != 0) mReg[wrAddr] = wrData;
    mPc  = expPc(mPc);
    mSp  = expSp(mSp);
    mPsr = expPsr(mPsr);
    @(negedge clk);
    check("R4 pc", pcOut, mPc);
    check("R5 sp", spOut, mSp);
    check("R6/R7/R8 status", statusOut, {11'b0, mPsr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    idle(); rdAddrA = 0; rdAddrB = 0; rst = 1;
    repeat (3) @(negedge clk);
    // R1: state after reset
    for (int i = 0; i < 8; i++) mReg[i] = 16'h0;
    mPc = 0; mSp = 0; mPsr = 0;
    check("R1 pc", pcOut, 16'h0);
    check("R1 sp", spOut, 16'h0);
    check("R1 status", statusOut, 16'h0);
    rst = 0;
    for (int i = 1; i < 8; i++) begin
      rdAddrA = 3'(i); #1; check("R1 reg", rdDataA, 16'h0); @(negedge clk);
    end

    // R2: write, same-cycle old value, then new value
    idle(); wrEn = 1; wrAddr = 3; wrData = 16'hBEEF; rdAddrA = 3; rdAddrB = 3;
    step();
    idle(); #1; check("R2 written", rdDataA, 16'hBEEF);

    // R3: write to R0 is dropped
    idle(); wrEn = 1; wrAddr = 0; wrData = 16'hFFFF; rdAddrA = 0; rdAddrB = 0;
    step();
    idle(); #1; check("R3 r0 after write", rdDataB, 16'h0);

    // R4: load beats increment, then increment wraps
    idle(); pcLoad = 1; pcInc = 1; pcLoadVal = 16'hFFFF; step();
    idle(); pcInc = 1; step();
    check("R4 wrap", pcOut, 16'h0000);

    // R5: decrement from zero wraps, conflicting steps hold, load beats steps
    idle(); spDec = 1; step();
    check("R5 dec wrap", spOut, 16'hFFFF);
    idle(); spInc = 1; spDec = 1; step();
    check("R5 conflict hold", spOut, 16'hFFFF);
    idle(); spLoad = 1; spInc = 1; spLoadVal = 16'h0100; step();

    // R8: full status write, high bits ignored, overrides flag and EI enables
    idle(); psrWrEn = 1; psrWrData = 16'hFFEA; flagEn = 4'hF; flagIn = 4'h5;
    eiWrEn = 1; eiIn = 0; step();
    check("R8 status", statusOut, 16'h000A);

    // R6 R7: selective flags, EI
    idle(); flagEn = 4'b0101; flagIn = 4'b1111; eiWrEn = 1; eiIn = 1; step();
    check("R6 R7 status", statusOut, 16'h001F);

    // R9: idle cycle holds all
    idle(); step();

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      wrEn = 1'($urandom); wrAddr = 3'($urandom); wrData = 16'($urandom);
      rdAddrA = 3'($urandom); rdAddrB = 3'($urandom);
      pcLoad = ($urandom % 4) == 0; pcInc = 1'($urandom); pcLoadVal = 16'($urandom);
      spLoad = ($urandom % 5) == 0; spInc = 1'($urandom); spDec = 1'($urandom);
      spLoadVal = 16'($urandom);
      flagEn = 4'($urandom); flagIn = 4'($urandom);
      eiWrEn = 1'($urandom); eiIn = 1'($urandom);
      psrWrEn = ($urandom % 6) == 0; psrWrData = 16'($urandom);
      step();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule